// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels. Each channel has a low count byte and a high count byte. It is configured through a small register port. A shared mode byte gives each channel a 2-bit count mode and a source select. The source is either every clock cycle (timer) or falling edges on the channel's external pin (counter). A shared control byte holds, for each channel, a run bit and a sticky overflow flag.

The four count modes are as follows. Mode 0 is a 13-bit count: a 5-bit prescaler in the low byte feeds an 8-bit high byte. Mode 1 is a 16-bit count. Mode 2 is an 8-bit count in the low byte that reloads from the high byte when it wraps. Mode 3 splits timer 0 into two 8-bit counters. Timer 0's low byte keeps timer 0's run bit and flag. Timer 0's high byte counts clock cycles under timer 1's run bit and sets timer 1's flag. While timer 0 is in mode 3, or timer 1 is itself placed in mode 3, timer 1 holds its count.

Software preloads the count bytes, selects the modes, sets the run bits, and polls or clears the flags.

Top module: `dual_timer`

## Requirements
- R1: After reset, every register reads 00h, both channels are stopped and both flags are clear.
- R2: Register map by `addr`. 0 is the control byte, read as {flag1, run1, flag0, run0, 0000b}, so bit 4 is run0, bit 5 is flag0, bit 6 is run1 and bit 7 is flag1; its low nibble reads zero. 1 is the mode byte, stored and read back whole; bits 1:0 are the timer 0 mode, bit 2 is the timer 0 source (1 = external pin), bits 5:4 are the timer 1 mode and bit 6 is the timer 1 source. 2 and 3 are timer 0 low and high. 4 and 5 are timer 1 low and high. A write lands at the clock edge that samples it, and `rdata` reflects the registers combinationally.
- R3: In mode 0, each count steps the low byte's 5 low bits. When they wrap from 31 to 0, the high byte steps, and the low byte's upper 3 bits stay unchanged. A wrap of the high byte from FFh sets the channel flag.
- R4: In mode 1, the count steps {high, low} as one 16-bit value, and the wrap from FFFFh to 0000h sets the channel flag.
- R5: In mode 2, the low byte steps. On a count at FFh it is loaded from the high byte instead, and the channel flag is set. The high byte is unchanged.
- R6: With timer 0 in mode 3, the low byte counts as 8 bits under run0 and sets flag0 on wrap. The high byte counts every clock under run1 and sets flag1 on wrap.
- R7: When timer 1's mode is 3, or timer 0's mode is 3, timer 1's count bytes hold their value whatever run1 is.
- R8: With its source bit set, a channel counts once per falling edge of its pin, two clock edges after the edge that first samples the low level. Rising edges do not count.
- R9: A channel whose run bit is 0 holds its count bytes.
- R10: A flag, once set, stays set until a control write changes it. A control write decides the flag value even when an overflow happens at the same edge.
- R11: A write to a count byte at the same edge as a count stores the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ext_in | input | 2 | External count pins, bit 0 for timer 0 |

## Verification
A register write is visible at the falling clock edge right after the rising edge that takes it. In timer mode, a channel started at rising edge E has made exactly N counts by the falling edge N cycles later. The checks therefore read the registers at falling edges and compute expected values from those edge counts. An external falling edge is counted at the third rising edge after the pin drops, so the bench waits four cycles after each pin change before it reads. Overflow and flag-clear races are placed on exact edges, and the registers are read at the very next falling edge.

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int PRE_BITS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [1:0] ext_in
);
  localparam logic [7:0] LO_MASK = 8'((1 << PRE_BITS) - 1);

  logic [7:0] t0_lo, t0_hi, t1_lo, t1_hi, mode_q;
  logic [1:0] run, flag;
  logic [1:0] sa, sb, sc;

  function automatic logic [16:0] step(input logic [1:0] m, input logic [7:0] lo, input logic [7:0] hi);
    logic [16:0] r;
    r = {1'b0, hi, lo};
    case (m)
      2'd0: if ((lo & LO_MASK) == LO_MASK) begin
              r[16:8] = {1'b0, hi} + 9'd1;
              r[7:0]  = lo & ~LO_MASK;
            end else r[7:0] = lo + 8'd1;
      2'd1: r = {1'b0, hi, lo} + 17'd1;
      2'd2: if (&lo) r = {1'b1, hi, hi};
            else r[7:0] = lo + 8'd1;
      default: begin
        r[16]  = &lo;
        r[7:0] = lo + 8'd1;
      end
    endcase
    return r;
  endfunction

  wire [1:0]  fall  = sc & ~sb;
  wire        split = (mode_q[1:0] == 2'd3);
  wire        tick0 = mode_q[2] ? fall[0] : 1'b1;
  wire        tick1 = mode_q[6] ? fall[1] : 1'b1;
  wire        en0   = run[0] & tick0;
  wire        en0h  = split & run[1];
  wire        en1   = run[1] & tick1 & ~split & (mode_q[5:4] != 2'd3);
  wire [16:0] s0    = step(mode_q[1:0], t0_lo, t0_hi);
  wire [16:0] s1    = step(mode_q[5:4], t1_lo, t1_hi);
  wire [8:0]  hi3   = {1'b0, t0_hi} + 9'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t0_lo <= '0; t0_hi <= '0; t1_lo <= '0; t1_hi <= '0;
      mode_q <= '0; run <= '0; flag <= '0;
      sa <= '0; sb <= '0; sc <= '0;
    end else begin
      sa <= ext_in; sb <= sa; sc <= sb;
      if (en0) begin
        t0_lo <= s0[7:0];
        if (!split) t0_hi <= s0[15:8];
        if (s0[16]) flag[0] <= 1'b1;
      end
      if (en0h) begin
        t0_hi <= hi3[7:0];
        if (hi3[8]) flag[1] <= 1'b1;
      end
      if (en1) begin
        t1_lo <= s1[7:0];
        t1_hi <= s1[15:8];
        if (s1[16]) flag[1] <= 1'b1;
      end
      if (wr_en) begin
        case (addr)
          3'd0: begin
            run  <= {wdata[6], wdata[4]};
            flag <= {wdata[7], wdata[5]};
          end
          3'd1: mode_q <= wdata;
          3'd2: t0_lo <= wdata;
          3'd3: t0_hi <= wdata;
          3'd4: t1_lo <= wdata;
          3'd5: t1_hi <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0: rdata = {flag[1], run[1], flag[0], run[0], 4'b0000};
      3'd1: rdata = mode_q;
      3'd2: rdata = t0_lo;
      3'd3: rdata = t0_hi;
      3'd4: rdata = t1_lo;
      3'd5: rdata = t1_hi;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] mode_q,
  input logic [1:0] run,
  input logic [1:0] flag,
  input logic [7:0] t0_lo,
  input logic [7:0] t0_hi,
  input logic [7:0] t1_lo,
  input logic [7:0] t1_hi
);
  wire w_ctrl = wr_en && addr == 3'd0;
  wire w_t0   = wr_en && (addr == 3'd2 || addr == 3'd3);
  wire w_t1   = wr_en && (addr == 3'd4 || addr == 3'd5);

  a_r7_t1_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd3 || mode_q[5:4] == 2'd3) && !w_t1 |=> $stable(t1_lo) && $stable(t1_hi));

  a_r9_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run[0] && mode_q[1:0] != 2'd3 && !w_t0 |=> $stable(t0_lo) && $stable(t0_hi));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag[0] && !w_ctrl |=> flag[0]);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    w_ctrl |=> flag[0] == $past(wdata[5]) && flag[1] == $past(wdata[7]));

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[2:0] == 3'b010 && run[0] && t0_lo == 8'hFF && !wr_en |=> t0_lo == $past(t0_hi) && flag[0]);

  a_r11_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 3'd2 |=> t0_lo == $past(wdata));
endmodule

bind dual_timer dual_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .mode_q(mode_q), .run(run), .flag(flag),
  .t0_lo(t0_lo), .t0_hi(t0_hi), .t1_lo(t1_lo), .t1_hi(t1_hi)
);

// File: tb/dual_timer_tb.sv
module dual_timer_tb;
  localparam int CLK_PERIOD = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] ext_in = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  dual_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .ext_in(ext_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    chk(req, int'(v), int'(e));
  endtask

  function automatic logic [16:0] model(input logic [1:0] m, input logic [7:0] lo, input logic [7:0] hi);
    logic [16:0] r;
    r = {1'b0, hi, lo};
    if (m == 2'd0) begin
      if (lo[4:0] == 5'd31) begin
        r[7:0] = {lo[7:5], 5'd0};
        r[16] = (hi == 8'hFF);
        r[15:8] = hi + 8'd1;
      end else r[7:0] = {lo[7:5], lo[4:0] + 5'd1};
    end else if (m == 2'd1) begin
      r[16] = ({hi, lo} == 16'hFFFF);
      r[15:0] = {hi, lo} + 16'd1;
    end else begin
      r[16] = (lo == 8'hFF);
      r[7:0] = (lo == 8'hFF) ? hi : lo + 8'd1;
    end
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 6; a++) expect_reg("R1 reset value", 3'(a), 8'h00);

    wr(1, 8'hA5); expect_reg("R2 mode readback", 1, 8'hA5);
    wr(0, 8'hFF); expect_reg("R2 control low nibble zero", 0, 8'hF0);
    wr(0, 8'h00); expect_reg("R2 control clear", 0, 8'h00);
    wr(1, 8'h00);

    // R9 run bit low holds
    wr(1, 8'h01); wr(2, 8'h12); wr(3, 8'h34);
    repeat (20) @(negedge clk);
    expect_reg("R9 hold low", 2, 8'h12);
    expect_reg("R9 hold high", 3, 8'h34);

    // R3 mode 0 prescaler wrap with upper bits kept
    wr(1, 8'h00); wr(2, 8'hFE); wr(3, 8'hFF); wr(0, 8'h10);
    @(negedge clk);
    expect_reg("R3 prescaler step", 2, 8'hFF);
    @(negedge clk);
    expect_reg("R3 low wrap keeps upper bits", 2, 8'hE0);
    expect_reg("R3 high wrap", 3, 8'h00);
    expect_reg("R3 flag set", 0, 8'h30);
    wr(0, 8'h00);

    // R4 mode 1 16-bit wrap
    wr(1, 8'h01); wr(2, 8'hFE); wr(3, 8'hFF); wr(0, 8'h10);
    @(negedge clk);
    expect_reg("R4 step", 2, 8'hFF);
    expect_reg("R4 no flag yet", 0, 8'h10);
    @(negedge clk);
    expect_reg("R4 wrap low", 2, 8'h00);
    expect_reg("R4 wrap high", 3, 8'h00);
    expect_reg("R4 flag", 0, 8'h30);
    wr(0, 8'h00);

    // R5 mode 2 reload
    wr(1, 8'h02); wr(2, 8'hFE); wr(3, 8'h80); wr(0, 8'h10);
    @(negedge clk);
    expect_reg("R5 step", 2, 8'hFF);
    @(negedge clk);
    expect_reg("R5 reload", 2, 8'h80);
    expect_reg("R5 high unchanged", 3, 8'h80);
    expect_reg("R5 flag", 0, 8'h30);
    wr(0, 8'h00);

    // R10 flag sticky and write priority, overflow every cycle
    wr(2, 8'hFF); wr(3, 8'hFF); wr(0, 8'h10);
    repeat (3) @(negedge clk);
    expect_reg("R10 flag sticky", 0, 8'h30);
    wr(0, 8'h10);
    expect_reg("R10 write wins over set", 0, 8'h10);
    @(negedge clk);
    expect_reg("R10 set again", 0, 8'h30);
    wr(0, 8'h00);

    // R11 byte write beats count
    wr(1, 8'h01); wr(2, 8'h00); wr(3, 8'h00); wr(0, 8'h10);
    repeat (3) @(negedge clk);
    wr(2, 8'h40);
    expect_reg("R11 written value", 2, 8'h40);
    @(negedge clk);
    expect_reg("R11 count resumes", 2, 8'h41);
    wr(0, 8'h00);

    // R8 external falling edges
    wr(1, 8'h05); wr(2, 8'h00); wr(3, 8'h00); wr(0, 8'h10);
    ext_in[0] = 1'b1;
    repeat (4) @(negedge clk);
    expect_reg("R8 rising edge ignored", 2, 8'h00);
    ext_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    expect_reg("R8 one fall one count", 2, 8'h01);
    for (int i = 0; i < 4; i++) begin
      ext_in[0] = 1'b1; repeat (4) @(negedge clk);
      ext_in[0] = 1'b0; repeat (4) @(negedge clk);
    end
    expect_reg("R8 five falls", 2, 8'h05);
    wr(0, 8'h00);

    // R6 split mode
    wr(1, 8'h03); wr(2, 8'hF0); wr(3, 8'hF8); wr(0, 8'h50);
    repeat (20) @(negedge clk);
    expect_reg("R6 low byte", 2, 8'h04);
    expect_reg("R6 high byte", 3, 8'h0C);
    expect_reg("R6 both flags", 0, 8'hF0);
    wr(0, 8'h00);
    wr(2, 8'h10); wr(3, 8'h20); wr(0, 8'h40);
    repeat (10) @(negedge clk);
    expect_reg("R6 low held by run0", 2, 8'h10);
    expect_reg("R6 high under run1", 3, 8'h2A);
    wr(0, 8'h00);

    // R7 timer 1 halted
    wr(1, 8'h13); wr(4, 8'h11); wr(5, 8'h22); wr(0, 8'h40);
    repeat (10) @(negedge clk);
    expect_reg("R7 split halts t1 low", 4, 8'h11);
    expect_reg("R7 split halts t1 high", 5, 8'h22);
    wr(0, 8'h00);
    wr(1, 8'h30); wr(0, 8'h40);
    repeat (10) @(negedge clk);
    expect_reg("R7 mode3 halts t1 low", 4, 8'h11);
    expect_reg("R7 mode3 halts t1 high", 5, 8'h22);
    expect_reg("R7 no flag", 0, 8'h40);
    wr(0, 8'h00);

    // random runs, both timers, modes 0..2 (R3 R4 R5 R10)
    for (int it = 0; it < 40; it++) begin
      logic [1:0] m0, m1;
      logic [7:0] a0, b0, a1, b1;
      logic f0, f1;
      logic [16:0] r;
      int n;
      m0 = 2'($urandom % 3); m1 = 2'($urandom % 3);
      a0 = 8'($urandom); b0 = 8'($urandom); a1 = 8'($urandom); b1 = 8'($urandom);
      if (it % 4 == 0) begin b0 = 8'hFF; a0 = 8'hF0; end
      n = 1 + int'($urandom % 400);
      wr(1, {2'b00, m1, 2'b00, m0});
      wr(2, a0); wr(3, b0); wr(4, a1); wr(5, b1);
      wr(0, 8'h50);
      repeat (n) @(negedge clk);
      f0 = 1'b0; f1 = 1'b0;
      for (int k = 0; k < n; k++) begin
        r = model(m0, a0, b0); a0 = r[7:0]; b0 = r[15:8]; f0 |= r[16];
        r = model(m1, a1, b1); a1 = r[7:0]; b1 = r[15:8]; f1 |= r[16];
      end
      expect_reg("R3/R4/R5 random t0 low", 2, a0);
      expect_reg("R3/R4/R5 random t0 high", 3, b0);
      expect_reg("R3/R4/R5 random t1 low", 4, a1);
      expect_reg("R3/R4/R5 random t1 high", 5, b1);
      expect_reg("R10 random flags", 0, {f1, 1'b1, f0, 1'b1, 4'b0000});
      wr(0, 8'h00);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule